// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A byte arrives over a valid/ready stream port. While a frame is on the wire the block refuses new bytes by holding `s_ready` low. A producer may hold `s_valid` high with its next byte for as long as it likes, and that byte is taken in the cycle after the current frame completes. A byte offered in the same cycle that `s_ready` is high is consumed at that clock edge. Nothing is buffered beyond the frame being sent.

The frame format comes from plain configuration pins:
- data length of six, seven or eight bits;
- one of five parity behaviours;
- a stop period of one, one and a half or two bit times.

Bit timing comes from a tick generator that divides the clock by an integer divisor. A selectable fixed divide-by-eight can be inserted ahead of that divisor. Sixteen ticks make one bit time.

The format pins and the divisor are sampled only at the edge where a byte is accepted. A frame therefore always finishes with the format it started with. The tick counters restart at that same edge, so every frame has exact timing relative to its acceptance.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1, `tx_busy` is 0 and `s_ready` is 1.
- R2: A byte is accepted at a rising clock edge where `s_valid` and `s_ready` are both 1. From the next cycle `tx_busy` is 1 and `s_ready` is 0 until the frame ends. While the frame is in progress, `s_valid` and `s_data` have no effect on the line.
- R3: `tx_line` goes to 0 (start bit) in the cycle after acceptance and stays 0 for one bit time. One bit time is 16 ticks.
- R4: After the start bit, data is sent least significant bit first. The bit count is set by `cfg_len_sel`: 2'b11 sends 6 bits, 2'b10 sends 7 bits, and 2'b00 or 2'b01 sends 8 bits. Unsent high bits of `s_data` have no effect.
- R5: After the data comes one parity bit, chosen by `cfg_par_sel`:
  - 3'b000: even (the sent data bits plus the parity bit hold an even number of ones);
  - 3'b001: odd;
  - 3'b010: always 0;
  - 3'b011: always 1;
  - any code with bit 2 set: no parity bit is sent.
- R6: The frame ends with `tx_line` at 1 for the stop period set by `cfg_stop_sel`: 2'b00 gives 16 ticks, 2'b01 gives 24 ticks, 2'b10 gives 32 ticks, and 2'b11 gives 16 ticks.
- R7: One tick lasts `cfg_divisor` clocks, with a divisor of 0 treated as 1. The tick lasts eight times as long when `cfg_pre8` is 1.
- R8: Configuration changes made during a frame do not alter that frame. They apply from the next acceptance.
- R9: If `s_valid` stays 1, `tx_busy` is 0 and `tx_line` is 1 for exactly one cycle after a frame ends. The next start bit begins in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pre8 | input | 1 | Insert a divide-by-eight ahead of the divisor |
| cfg_divisor | input | DIV_W | Clocks per tick (0 acts as 1) |
| cfg_len_sel | input | 2 | Data length select |
| cfg_par_sel | input | 3 | Parity behaviour select |
| cfg_stop_sel | input | 2 | Stop period select |
| s_data | input | 8 | Byte to send |
| s_valid | input | 1 | Byte offered |
| s_ready | output | 1 | Block can accept a byte |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | Frame in progress |

## Verification
The bench keeps the default `DIV_W` of 12 and drives the divisor at run time. Most frames use a divisor of 1 without the prescaler, which gives a 16-clock bit time, so every data length, parity code and stop code fits in a few hundred cycles. Two frames use a divisor of 3, and a divisor of 2 with the prescaler, to measure tick length through the position of each bit's midpoint and of the frame end. A divisor of 0 is also exercised. One scenario holds `s_valid` high across two frames to pin down the one-cycle idle gap and the immunity of an in-flight frame to new data and format.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

  localparam int unsigned TICKS_PER_BIT = 16;
  localparam int unsigned TCNT_W        = 6;
  localparam int unsigned CHAR_MAX      = 8;
  localparam int unsigned BIDX_W        = $clog2(CHAR_MAX);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  typedef enum logic [2:0] {
    PK_EVEN,
    PK_ODD,
    PK_ZERO,
    PK_ONE,
    PK_NONE
  } par_kind_e;

  typedef struct packed {
    logic       pre8;
    logic [1:0] len_sel;
    logic [2:0] par_sel;
    logic [1:0] stop_sel;
  } cfg_t;

  typedef struct packed {
    logic [3:0]        nbits;
    par_kind_e         par_kind;
    logic [TCNT_W-1:0] stop_ticks;
  } fmt_t;

endpackage

// File: rtl/uftx_fmt_decode.sv
module uftx_fmt_decode
  import uftx_pkg::*;
(
  input  cfg_t cfg,
  output fmt_t fmt
);

  always_comb begin
    unique case (cfg.len_sel)
      2'b11:   fmt.nbits = 4'd6;
      2'b10:   fmt.nbits = 4'd7;
      default: fmt.nbits = 4'd8;
    endcase

    if (cfg.par_sel[2]) begin
      fmt.par_kind = PK_NONE;
    end else begin
      unique case (cfg.par_sel[1:0])
        2'b00:   fmt.par_kind = PK_EVEN;
        2'b01:   fmt.par_kind = PK_ODD;
        2'b10:   fmt.par_kind = PK_ZERO;
        default: fmt.par_kind = PK_ONE;
      endcase
    end

    unique case (cfg.stop_sel)
      2'b01:   fmt.stop_ticks = TCNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
      2'b10:   fmt.stop_ticks = TCNT_W'(2 * TICKS_PER_BIT);
      default: fmt.stop_ticks = TCNT_W'(TICKS_PER_BIT);
    endcase
  end

endmodule

// File: rtl/uftx_baud_gen.sv
module uftx_baud_gen #(
  parameter int unsigned DIV_W     = 12,
  parameter int unsigned PRE_RATIO = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             pre_on,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  localparam int unsigned PRE_W = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1;

  logic             pre_en;
  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] div_cnt_q;
  logic             div_end;

  generate
    if (PRE_RATIO > 1) begin : g_pre
      logic [PRE_W-1:0] pre_cnt_q;
      logic             pre_end;

      assign pre_end = (pre_cnt_q == PRE_W'(PRE_RATIO - 1));
      assign pre_en  = !pre_on || pre_end;

      always_ff @(posedge clk) begin
        if (!rst_n || clear || !pre_on) begin
          pre_cnt_q <= '0;
        end else if (pre_end) begin
          pre_cnt_q <= '0;
        end else begin
          pre_cnt_q <= pre_cnt_q + 1'b1;
        end
      end
    end else begin : g_nopre
      assign pre_en = 1'b1;
    end
  endgenerate

  assign div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign div_end = (div_cnt_q == div_eff - 1'b1);
  assign tick    = pre_en && div_end && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      div_cnt_q <= '0;
    end else if (pre_en) begin
      if (div_end) begin
        div_cnt_q <= '0;
      end else begin
        div_cnt_q <= div_cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/uftx_frame_fsm.sv
module uftx_frame_fsm
  import uftx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CHAR_MAX-1:0] data_in,
  input  fmt_t                fmt,
  input  logic                tick,
  output logic                line,
  output logic                busy
);

  tx_state_e           state_q;
  logic [TCNT_W-1:0]   tcnt_q;
  logic [BIDX_W-1:0]   bidx_q;
  logic [CHAR_MAX-1:0] data_q;
  logic                line_q;

  logic [CHAR_MAX-1:0] len_mask;
  logic                par_bit;
  logic                bit_end;
  logic                stop_end;
  logic                last_data;

  for (genvar i = 0; i < CHAR_MAX; i++) begin : g_mask
    assign len_mask[i] = (4'(i) < fmt.nbits);
  end

  always_comb begin
    unique case (fmt.par_kind)
      PK_EVEN: par_bit = ^(data_q & len_mask);
      PK_ODD:  par_bit = ~^(data_q & len_mask);
      PK_ONE:  par_bit = 1'b1;
      default: par_bit = 1'b0;
    endcase
  end

  assign bit_end   = tick && (tcnt_q == TCNT_W'(TICKS_PER_BIT - 1));
  assign stop_end  = tick && (tcnt_q == fmt.stop_ticks - 1'b1);
  assign last_data = ({1'b0, bidx_q} == fmt.nbits - 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      data_q  <= '0;
      line_q  <= 1'b1;
    end else if (state_q == ST_IDLE) begin
      if (start) begin
        state_q <= ST_START;
        tcnt_q  <= '0;
        bidx_q  <= '0;
        data_q  <= data_in;
        line_q  <= 1'b0;
      end
    end else if (tick) begin
      tcnt_q <= tcnt_q + 1'b1;
      unique case (state_q)
        ST_START: begin
          if (bit_end) begin
            tcnt_q  <= '0;
            state_q <= ST_DATA;
            line_q  <= data_q[0];
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            tcnt_q <= '0;
            if (last_data) begin
              if (fmt.par_kind == PK_NONE) begin
                state_q <= ST_STOP;
                line_q  <= 1'b1;
              end else begin
                state_q <= ST_PARITY;
                line_q  <= par_bit;
              end
            end else begin
              bidx_q <= bidx_q + 1'b1;
              line_q <= data_q[bidx_q + 1'b1];
            end
          end
        end
        ST_PARITY: begin
          if (bit_end) begin
            tcnt_q  <= '0;
            state_q <= ST_STOP;
            line_q  <= 1'b1;
          end
        end
        ST_STOP: begin
          if (stop_end) begin
            tcnt_q  <= '0;
            state_q <= ST_IDLE;
            line_q  <= 1'b1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          line_q  <= 1'b1;
        end
      endcase
    end
  end

  assign line = line_q;
  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uftx_pkg::*;
#(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_pre8,
  input  logic [DIV_W-1:0] cfg_divisor,
  input  logic [1:0]       cfg_len_sel,
  input  logic [2:0]       cfg_par_sel,
  input  logic [1:0]       cfg_stop_sel,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  output logic             s_ready,
  output logic             tx_line,
  output logic             tx_busy
);

  cfg_t             cfg_q;
  logic [DIV_W-1:0] div_q;
  fmt_t             fmt;
  logic             accept;
  logic             tick;
  logic             busy;

  assign s_ready = !busy;
  assign accept  = s_valid && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      div_q <= '0;
    end else if (accept) begin
      cfg_q <= '{pre8: cfg_pre8, len_sel: cfg_len_sel,
                 par_sel: cfg_par_sel, stop_sel: cfg_stop_sel};
      div_q <= cfg_divisor;
    end
  end

  uftx_fmt_decode u_dec (
    .cfg (cfg_q),
    .fmt (fmt)
  );

  uftx_baud_gen #(
    .DIV_W     (DIV_W),
    .PRE_RATIO (8)
  ) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .pre_on  (cfg_q.pre8),
    .divisor (div_q),
    .tick    (tick)
  );

  uftx_frame_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .data_in (s_data),
    .fmt     (fmt),
    .tick    (tick),
    .line    (tx_line),
    .busy    (busy)
  );

  assign tx_busy = busy;

endmodule

// File: rtl/uftx_checker.sv
module uftx_checker
  import uftx_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic tx_line,
  input logic tx_busy,
  input cfg_t cfg_q
);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line); // R1

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (tx_busy && !s_ready)); // R2

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !tx_line); // R3

  AST_FRAME_ENDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $past(tx_line)); // R6

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && $past(tx_busy)) |-> $stable(cfg_q)); // R8

endmodule

bind uart_frame_tx uftx_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .tx_line (tx_line),
  .tx_busy (tx_busy),
  .cfg_q   (cfg_q)
);

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;

  localparam int DIV_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_pre8 = 1'b0;
  logic [DIV_W-1:0] cfg_divisor = '0;
  logic [1:0]       cfg_len_sel = '0;
  logic [2:0]       cfg_par_sel = '0;
  logic [1:0]       cfg_stop_sel = '0;
  logic [7:0]       s_data = '0;
  logic             s_valid = 1'b0;
  logic             s_ready;
  logic             tx_line;
  logic             tx_busy;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  uart_frame_tx #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_pre8(cfg_pre8), .cfg_divisor(cfg_divisor),
    .cfg_len_sel(cfg_len_sel), .cfg_par_sel(cfg_par_sel),
    .cfg_stop_sel(cfg_stop_sel), .s_data(s_data), .s_valid(s_valid),
    .s_ready(s_ready), .tx_line(tx_line), .tx_busy(tx_busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Offer a byte at a falling edge, wait for the accepting rising edge.
  task automatic offer(input logic [7:0] d, input logic [1:0] ln, input logic [2:0] pr,
                       input logic [1:0] sp, input logic p8, input int dv);
    @(negedge clk);
    s_data = d; cfg_len_sel = ln; cfg_par_sel = pr; cfg_stop_sel = sp;
    cfg_pre8 = p8; cfg_divisor = DIV_W'(dv);
    s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  // Called just after the accepting edge; returns just after the edge that ends the frame.
  task automatic check_frame(input logic [7:0] d, input logic [1:0] ln, input logic [2:0] pr,
                             input logic [1:0] sp, input logic p8, input int dv);
    int nb, body, stp, c, t, cur, tgt;
    bit pbit;
    bit exp_bits[11];
    nb  = ln[1] ? (ln[0] ? 6 : 7) : 8;
    stp = (sp == 2'b01) ? 24 : ((sp == 2'b10) ? 32 : 16);
    c   = ((dv == 0) ? 1 : dv) * (p8 ? 8 : 1);
    t   = 16 * c;
    exp_bits[0] = 1'b0;
    pbit = 1'b0;
    for (int i = 0; i < nb; i++) begin
      exp_bits[1 + i] = d[i];
      pbit = pbit ^ d[i];
    end
    body = 1 + nb;
    if (!pr[2]) begin
      case (pr[1:0])
        2'b00: exp_bits[body] = pbit;
        2'b01: exp_bits[body] = !pbit;
        2'b10: exp_bits[body] = 1'b0;
        default: exp_bits[body] = 1'b1;
      endcase
      body++;
    end
    cur = 0;
    for (int k = 0; k < body; k++) begin
      tgt = k * t + t / 2;
      repeat (tgt - cur) @(posedge clk);
      #2;
      cur = tgt;
      if (k == 0)            chk(tx_line == 1'b0, "R3 start bit", tx_line, 0);
      else if (k <= nb)      chk(tx_line == exp_bits[k], "R4 data bit", tx_line, exp_bits[k]);
      else                   chk(tx_line == exp_bits[k], "R5 parity bit", tx_line, exp_bits[k]);
    end
    tgt = body * t + (stp * c) / 2;
    repeat (tgt - cur) @(posedge clk);
    #2;
    cur = tgt;
    chk(tx_line == 1'b1, "R6 stop level", tx_line, 1);
    tgt = body * t + stp * c - 1;
    repeat (tgt - cur) @(posedge clk);
    #2;
    cur = tgt;
    chk(tx_busy == 1'b1 && s_ready == 1'b0, "R6 R7 still busy before end", tx_busy, 1);
    @(posedge clk);
    #2;
    chk(tx_busy == 1'b0 && s_ready == 1'b1 && tx_line == 1'b1,
        "R6 R7 frame ended on time", tx_busy, 0);
  endtask

  task automatic t_reset();
    #2;
    chk(tx_line == 1'b1, "R1 reset line", tx_line, 1);
    chk(s_ready == 1'b1 && tx_busy == 1'b0, "R1 reset ready", s_ready, 1);
  endtask

  task automatic t_frame(input logic [7:0] d, input logic [1:0] ln, input logic [2:0] pr,
                         input logic [1:0] sp, input logic p8, input int dv);
    offer(d, ln, pr, sp, p8, dv);
    s_valid = 1'b0;
    chk(tx_busy == 1'b1 && s_ready == 1'b0, "R2 busy after accept", tx_busy, 1);
    check_frame(d, ln, pr, sp, p8, dv);
  endtask

  task automatic t_cfg_midframe();
    offer(8'h3C, 2'b00, 3'b001, 2'b00, 1'b0, 1);
    s_valid = 1'b0;
    cfg_len_sel = 2'b11; cfg_par_sel = 3'b100; cfg_stop_sel = 2'b10;
    cfg_divisor = DIV_W'(4); cfg_pre8 = 1'b1;
    check_frame(8'h3C, 2'b00, 3'b001, 2'b00, 1'b0, 1); // R8
  endtask

  task automatic t_back_to_back();
    offer(8'hC5, 2'b10, 3'b000, 2'b01, 1'b0, 1);
    s_data = 8'h0F; // R2: new data while busy, ignored by current frame
    check_frame(8'hC5, 2'b10, 3'b000, 2'b01, 1'b0, 1);
    @(posedge clk);
    #2;
    chk(tx_line == 1'b0 && tx_busy == 1'b1, "R9 next start after one idle cycle", tx_line, 0);
    s_valid = 1'b0;
    check_frame(8'h0F, 2'b10, 3'b000, 2'b01, 1'b0, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();                                         // R1
    t_frame(8'hA5, 2'b00, 3'b000, 2'b00, 1'b0, 1);     // R3 R4 R5 even, defaults
    t_frame(8'hFB, 2'b10, 3'b001, 2'b00, 1'b0, 1);     // R4 7 bits, R5 odd
    t_frame(8'hC9, 2'b11, 3'b011, 2'b00, 1'b0, 1);     // R4 6 bits, R5 forced one
    t_frame(8'h7E, 2'b01, 3'b010, 2'b00, 1'b0, 1);     // R4 code 01, R5 forced zero
    t_frame(8'h96, 2'b00, 3'b110, 2'b00, 1'b0, 1);     // R5 no parity
    t_frame(8'h55, 2'b00, 3'b100, 2'b01, 1'b0, 1);     // R6 1.5 stop
    t_frame(8'h01, 2'b00, 3'b000, 2'b10, 1'b0, 1);     // R6 two stops
    t_frame(8'h80, 2'b00, 3'b001, 2'b11, 1'b0, 1);     // R6 reserved code
    t_frame(8'h6D, 2'b11, 3'b000, 2'b00, 1'b0, 3);     // R7 divisor 3
    t_frame(8'h2B, 2'b00, 3'b100, 2'b01, 1'b1, 2);     // R7 prescale with divisor 2
    t_frame(8'h4E, 2'b10, 3'b001, 2'b00, 1'b0, 0);     // R7 divisor zero
    t_cfg_midframe();                                  // R8
    t_back_to_back();                                  // R2 R9
    repeat (2) @(posedge clk);
    #2;
    chk(tx_line == 1'b1 && s_ready == 1'b1, "R1 idle after traffic", tx_line, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule